// File: doc/BRIEF.md
# Reference-Locked One-Hertz Divider

This block turns a fast oscillator clock into a once-per-second tick and holds that tick in step with a second once-per-second tick made from an external reference. The reference input is resynchronised into the oscillator domain. A prescaler then divides it by one of four divisors, and a 2-bit select picks the divisor. Lock does not align the two ticks. When the first acceptable reference tick arrives, the block records the position of that tick inside the oscillator second, and that position becomes the target from then on.

While the reference period stays close to the oscillator period, the block lets the offset from the target grow. Once the offset reaches a skew limit, the block lengthens or shortens exactly one oscillator second by the full offset, counted in whole oscillator cycles. A reference that is too fast, too slow or missing stops all correction, drops lock and sets a sticky loss flag. When a good reference comes back, lock is taken again at whatever offset exists at that moment.

A square-wave output selects either the corrected second, as a half-high wave, or one of three faster taps. The taps come from a free-running counter that correction never touches.

Top module: `sec_lock_div`

## Requirements
- R1: With no correction pending, `tick` pulses for one cycle every 2^DIV_W clock cycles.
- R2: `ref_in` passes through a two-flop synchroniser. One reference tick is made every N rising edges, where N is PRE_DIV0, PRE_DIV1, PRE_DIV2 or PRE_DIV3 for `ref_sel` values 0, 1, 2 and 3.
- R3: A reference tick is accepted when its spacing from the previous one is between 2^DIV_W-TOL and 2^DIV_W+TOL cycles inclusive. The first accepted tick while unlocked raises `lock` and stores the current phase (the divider count, 0 to 2^DIV_W-1) as the target, whatever its value.
- R4: At an accepted tick while locked, the drift is (phase - target) mod 2^DIV_W, read as signed. If its magnitude is at least SKEW_LIM, the next full `tick` period is 2^DIV_W + drift cycles, so a late reference lengthens the period. Smaller drift changes nothing.
- R5: Once a correction is decided, no further drift is evaluated until the correction has been applied and one more accepted tick has passed.
- R6: An out-of-range spacing, or no reference tick within 2^DIV_W+TOL cycles of the previous one, sets `los` and clears `lock`. The divider then runs at 2^DIV_W with no correction.
- R7: `los` stays at 1 until a cycle with `los_clr` high, and a fresh loss in the same cycle wins over the clear.
- R8: After a loss, the next accepted tick relocks at the phase current at that moment, and later corrections are measured from this new target.
- R9: `sqw_sel` 0 gives the corrected second, high while the divider count is below 2^(DIV_W-1). Values 1, 2 and 3 give bits TAP_HI, TAP_MID and TAP_LO of a free-running counter that correction never alters.
- R10: After reset, `lock` and `los` are 0 and the divider count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | External reference, asynchronous |
| ref_sel | input | 2 | Prescaler divisor select |
| los_clr | input | 1 | Clears the loss flag |
| sqw_sel | input | 2 | Square-wave source select |
| tick | output | 1 | Corrected once-per-second pulse |
| sqw_out | output | 1 | Selected square wave |
| lock | output | 1 | Phase target held |
| los | output | 1 | Sticky reference loss flag |

## Verification
A corrupted divider count or period limit shows at once as a `tick` spacing other than 2^DIV_W. A wrong stored target, or a skipped settle interval, shows within a few reference seconds: a corrected period appears with the wrong size, or an extra one appears. A faulty spacing counter shows as `los` rising, or failing to rise, within 2^DIV_W+TOL cycles of the last reference tick. Tap damage shows as a change in the tap edge phase measured against the cycle count from reset.

// File: rtl/sec_lock_div.sv
module sec_lock_div #(
  parameter int DIV_W    = 15,
  parameter int SKEW_LIM = 256,
  parameter int TOL      = 262,
  parameter int PRE_DIV0 = 1,
  parameter int PRE_DIV1 = 50,
  parameter int PRE_DIV2 = 60,
  parameter int PRE_DIV3 = 32768,
  parameter int TAP_HI   = 1,
  parameter int TAP_MID  = 2,
  parameter int TAP_LO   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic [1:0] ref_sel,
  input  logic       los_clr,
  input  logic [1:0] sqw_sel,
  output logic       tick,
  output logic       sqw_out,
  output logic       lock,
  output logic       los
);
  localparam int PER = 1 << DIV_W;
  localparam int CW  = DIV_W + 1;
  localparam int RW  = TAP_LO + 1;
  localparam int M01 = PRE_DIV0 > PRE_DIV1 ? PRE_DIV0 : PRE_DIV1;
  localparam int M23 = PRE_DIV2 > PRE_DIV3 ? PRE_DIV2 : PRE_DIV3;
  localparam int PRE_MAX = M01 > M23 ? M01 : M23;
  localparam int PW  = $clog2(PRE_MAX + 1);
  localparam logic [CW-1:0]    NOM_TOP = CW'(PER - 1);
  localparam logic [CW-1:0]    GAP_LO  = CW'(PER - TOL);
  localparam logic [CW-1:0]    GAP_HI  = CW'(PER + TOL);
  localparam logic [CW-1:0]    HALF    = CW'(PER / 2);
  localparam logic [DIV_W-1:0] LIM     = DIV_W'(SKEW_LIM);
  localparam logic [RW-1:0]    M_HI    = RW'(1) << TAP_HI;
  localparam logic [RW-1:0]    M_MID   = RW'(1) << TAP_MID;
  localparam logic [RW-1:0]    M_LO    = RW'(1) << TAP_LO;

  logic [2:0]       sync;
  logic [PW-1:0]    pre_cnt, pre_top;
  logic [CW-1:0]    cnt, top, gap;
  logic [RW-1:0]    raw;
  logic [DIV_W-1:0] lock_ofs, adj;
  logic             have_prev, locked, pend, settle, los_q;

  wire              rise     = sync[1] & ~sync[2];
  wire              ref_tick = rise && (pre_cnt >= pre_top);
  wire              wrap     = (cnt == top);
  wire [DIV_W-1:0]  phase    = cnt[DIV_W-1:0];
  wire [DIV_W-1:0]  diff     = phase - lock_ofs;
  wire [DIV_W-1:0]  mag      = diff[DIV_W-1] ? -diff : diff;
  wire              in_tol   = (gap >= GAP_LO) && (gap <= GAP_HI);
  wire              good     = ref_tick && have_prev && in_tol;
  wire              timeout  = !ref_tick && have_prev && (gap == GAP_HI);
  wire              bad      = (ref_tick && have_prev && !in_tol) || timeout;
  wire              fix      = good && locked && !pend && !settle && (mag >= LIM);

  always_comb begin
    case (ref_sel)
      2'd0:    pre_top = PW'(PRE_DIV0 - 1);
      2'd1:    pre_top = PW'(PRE_DIV1 - 1);
      2'd2:    pre_top = PW'(PRE_DIV2 - 1);
      default: pre_top = PW'(PRE_DIV3 - 1);
    endcase
  end

  always_comb begin
    case (sqw_sel)
      2'd0:    sqw_out = cnt < HALF;
      2'd1:    sqw_out = |(raw & M_HI);
      2'd2:    sqw_out = |(raw & M_MID);
      default: sqw_out = |(raw & M_LO);
    endcase
  end

  assign tick = wrap;
  assign lock = locked;
  assign los  = los_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync      <= '0;
      pre_cnt   <= '0;
      raw       <= '0;
      cnt       <= '0;
      top       <= NOM_TOP;
      gap       <= '0;
      lock_ofs  <= '0;
      adj       <= '0;
      have_prev <= 1'b0;
      locked    <= 1'b0;
      pend      <= 1'b0;
      settle    <= 1'b0;
      los_q     <= 1'b0;
    end else begin
      sync <= {sync[1:0], ref_in};
      raw  <= raw + RW'(1);
      if (rise) pre_cnt <= ref_tick ? '0 : pre_cnt + PW'(1);

      if (wrap) begin
        cnt <= '0;
        top <= pend ? NOM_TOP + {adj[DIV_W-1], adj} : NOM_TOP;
      end else begin
        cnt <= cnt + CW'(1);
      end

      if (ref_tick) begin
        gap       <= CW'(1);
        have_prev <= 1'b1;
      end else if (timeout) begin
        have_prev <= 1'b0;
      end else if (have_prev) begin
        gap <= gap + CW'(1);
      end

      if (good && !locked) begin
        locked   <= 1'b1;
        lock_ofs <= phase;
      end
      if (good && locked && settle && !pend) settle <= 1'b0;
      if (fix) begin
        pend <= 1'b1;
        adj  <= diff;
      end
      if (wrap && pend) begin
        pend   <= 1'b0;
        settle <= 1'b1;
      end

      if (los_clr) los_q <= 1'b0;
      if (bad) begin
        los_q  <= 1'b1;
        locked <= 1'b0;
        pend   <= 1'b0;
        settle <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sec_lock_div_chk.sv
module sec_lock_div_chk #(
  parameter int DIV_W    = 15,
  parameter int SKEW_LIM = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             lock,
  input logic             los,
  input logic             los_clr,
  input logic             ref_tick,
  input logic [DIV_W:0]   cnt,
  input logic [DIV_W:0]   top
);
  localparam int PER = 1 << DIV_W;
  localparam logic [DIV_W:0] NOM    = (DIV_W+1)'(PER - 1);
  localparam logic [DIV_W:0] LONG_M = (DIV_W+1)'(PER - 1 + SKEW_LIM);
  localparam logic [DIV_W:0] SHRT_M = (DIV_W+1)'(PER - 1 - SKEW_LIM);

  p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top);

  p_lock_on_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(ref_tick));

  p_fix_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && top != NOM) |-> (top >= LONG_M || top <= SHRT_M));

  p_loss_unlocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los) |-> !lock);

  p_los_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (los && !los_clr) |=> los);
endmodule

bind sec_lock_div sec_lock_div_chk #(.DIV_W(DIV_W), .SKEW_LIM(SKEW_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .lock(lock), .los(los),
  .los_clr(los_clr), .ref_tick(ref_tick), .cnt(cnt), .top(top)
);

// File: tb/sec_lock_div_tb.sv
module sec_lock_div_tb;
  localparam int DW = 10;
  localparam int P  = 1 << DW;

  logic clk = 0, rst_n = 0, ref_in = 0, los_clr = 0;
  logic [1:0] ref_sel = 0, sqw_sel = 0;
  wire tick, sqw_out, lock, los;

  sec_lock_div #(.DIV_W(DW), .SKEW_LIM(8), .TOL(8), .PRE_DIV0(1), .PRE_DIV1(4),
                 .PRE_DIV2(6), .PRE_DIV3(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .ref_sel(ref_sel), .los_clr(los_clr),
    .sqw_sel(sqw_sel), .tick(tick), .sqw_out(sqw_out), .lock(lock), .los(los));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int exp_q[$];
  int last_tick = -1, first_iv = -1, iv = 0, want = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: every off-nominal period must match the next queued correction
  always @(negedge clk) begin
    if (rst_n && tick) begin
      if (last_tick >= 0) begin
        iv = cyc - last_tick;
        if (first_iv < 0) first_iv = iv;
        if (iv != P) begin
          if (exp_q.size() == 0) chk("R4 R5 unexpected period", iv, P);
          else begin
            want = P + exp_q.pop_front();
            chk("R4 corrected period", iv, want);
          end
        end
      end
      last_tick = cyc;
    end
  end

  task automatic pulse_ref(int n, int spacing);
    for (int i = 0; i < n; i++) begin
      ref_in = 1;
      repeat (4) @(negedge clk);
      ref_in = 0;
      repeat (spacing - 4) @(negedge clk);
    end
  endtask

  task automatic clear_los();
    los_clr = 1;
    @(negedge clk);
    los_clr = 0;
    @(negedge clk);
  endtask

  task automatic find_rise();
    logic prev;
    prev = sqw_out;
    @(negedge clk);
    while (!(sqw_out && !prev)) begin
      prev = sqw_out;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int run, rises, res0;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 lock after reset", lock, 0);
    chk("R10 los after reset", los, 0);
    chk("R10 1Hz wave high after reset", sqw_out, 1);

    while (sqw_out) @(negedge clk);
    while (!sqw_out) @(negedge clk);
    run = 0;
    while (sqw_out) begin run++; @(negedge clk); end
    chk("R9 1Hz high time", run, P / 2);

    sqw_sel = 1;
    @(negedge clk);
    rises = 0;
    prev = sqw_out;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (sqw_out && !prev) rises++;
      prev = sqw_out;
    end
    chk("R9 fast tap edges", rises, 16);

    sqw_sel = 3;
    find_rise();
    res0 = cyc % 32;

    while (first_iv < 0) @(negedge clk);
    chk("R1 nominal period", first_iv, P);

    // late reference, drift +3 per second: corrections of +9 twice (R4, R5)
    exp_q.push_back(9);
    exp_q.push_back(9);
    pulse_ref(2, P + 3);
    chk("R3 lock after accepted tick", lock, 1);
    pulse_ref(6, P + 3);
    chk("R6 no loss in tolerance", los, 0);
    repeat (3000) @(negedge clk);
    chk("R5 corrections consumed", exp_q.size(), 0);
    chk("R6 loss on missing reference", los, 1);
    chk("R6 unlock on loss", lock, 0);
    repeat (2000) @(negedge clk);
    chk("R7 loss flag sticky", los, 1);
    clear_los();
    chk("R7 loss flag cleared", los, 0);

    // early reference at a new offset: one correction of -9 (R8)
    repeat (333) @(negedge clk);
    exp_q.push_back(-9);
    pulse_ref(2, P - 3);
    chk("R8 relock after loss", lock, 1);
    pulse_ref(3, P - 3);
    repeat (3000) @(negedge clk);
    chk("R8 correction from new target", exp_q.size(), 0);
    clear_los();

    // out of tolerance both ways: no correction, loss held
    pulse_ref(4, P + 20);
    chk("R6 slow reference sets loss", los, 1);
    chk("R6 slow reference no lock", lock, 0);
    pulse_ref(4, P - 20);
    chk("R6 fast reference no lock", lock, 0);
    repeat (2000) @(negedge clk);
    clear_los();
    chk("R7 clear after bad reference", los, 0);

    // prescaler divisor 4: edges every (P+4)/4 cycles, one +8 correction
    ref_sel = 1;
    exp_q.push_back(8);
    pulse_ref(16, (P + 4) / 4);
    chk("R2 lock through prescaler", lock, 1);
    chk("R2 no loss through prescaler", los, 0);
    repeat (2500) @(negedge clk);
    chk("R2 prescaled correction seen", exp_q.size(), 0);

    find_rise();
    chk("R9 tap phase unaffected by correction", cyc % 32, res0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule